// File: doc/BRIEF.md
# Pattern-Table Timed Scan Sequencer

This block runs a converter through a repeating list of measurements. Software fills a small table of 8-bit measurement entries, each naming a channel and an attenuation code, and programs a trigger interval. Once the timer is selected and enabled, every trigger takes the next entry from the table, drives it to the converter and issues a one-cycle start. The block then waits for the converter's done strobe and forwards the returned sample on a valid/data stream.

Entries are packed four to a 32-bit table word, and each write replaces a single entry. The scan walks entries 0 up to a programmable last index and then wraps. A pointer-clear pulse sends it back to entry 0. The stream can carry the bitwise complement of each sample. An end-of-frame flag marks every Nth sample, where N is programmable. A trigger that comes while the converter is still busy is dropped and sets a sticky overrun flag.

Top module: `scan_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `conv_start`, `smp_valid`, `smp_eof` and `overrun` are all 0.
- R2: Writing entry index k (word k/4, byte slot k%4, slot 0 in bits [31:24] of the word) changes only that entry. The other three entries of the same word keep their values.
- R3: At each `conv_start`, `conv_chan` equals bits [7:4] and `conv_atten` equals bits [3:2] of the entry being used. Both hold steady until the next start.
- R4: With the timer running and a converter that finishes in time, consecutive `conv_start` pulses are exactly 2×`interval` clock cycles apart. Each start lasts one cycle.
- R5: An `interval` value below 40 behaves as 40, which gives a spacing of 80 cycles.
- R6: No start is issued unless both `tmr_sel` and `tmr_en` are 1. Clearing either one stops all further starts.
- R7: Entries are used in index order 0, 1, …, `pat_len`. After entry `pat_len` the scan returns to entry 0.
- R8: After a `ptr_clr` pulse, the next conversion uses entry 0.
- R9: One cycle after `conv_done` is accepted, `smp_valid` is 1 for one cycle and `smp_data` equals `conv_data`.
- R10: When `inv_en` is 1 in the accepting cycle, `smp_data` is the bitwise complement of `conv_data`.
- R11: `smp_eof` is 1 together with every `frame_len`-th sample. A `frame_len` of 0 counts as 1.
- R12: A trigger that arrives while a conversion is outstanding is dropped: no start is issued, and `overrun` becomes 1 and stays 1 until reset. A trigger that falls in the same cycle as the `conv_done` that ends the conversion is accepted and does not set `overrun`.
- R13: A `conv_done` that arrives while no conversion is outstanding produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Entry write strobe |
| tbl_wr_idx | input | 4 | Entry index to write (word = idx/4, slot = idx%4) |
| tbl_wr_data | input | 8 | New entry: [7:4] channel, [3:2] attenuation, [1:0] unused |
| ptr_clr | input | 1 | Return the scan to entry 0 |
| tmr_sel | input | 1 | Select the interval timer as trigger source |
| tmr_en | input | 1 | Enable the interval timer |
| interval | input | 12 | Trigger interval; triggers come every 2×max(interval,40) cycles |
| pat_len | input | 4 | Index of the last entry in the scan |
| frame_len | input | 8 | Samples per frame |
| inv_en | input | 1 | Output the complement of each sample |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_atten | output | 2 | Attenuation code for the current conversion |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 12 | Converter result, valid with conv_done |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 12 | Sample value |
| smp_eof | output | 1 | Last sample of a frame |
| overrun | output | 1 | Sticky: a trigger was dropped |

## Verification
The timer trigger and the converter's done strobe can land in the same cycle. The block must free the converter and relaunch it in that cycle rather than drop the trigger. The bench sets up this case with a converter model whose latency is exactly one trigger period minus one cycle, so that done lines up with the next timer fire. It then expects the start spacing to stay at 2×interval and `overrun` to stay 0. A second run with the latency longer than two periods checks the opposite case: the intermediate triggers must be dropped, the next start must come at the first fire after done (240 cycles for an interval of 40), and `overrun` must rise.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int ENT_W     = 8;
  localparam int SLOTS     = 4;
  localparam int CHAN_W    = 4;
  localparam int ATT_W     = 2;
  localparam int IVL_FLOOR = 40;

  // Slot 0 is the most significant byte of a table word.
  function automatic logic [ENT_W-1:0] slot_get(input logic [31:0] word, input logic [1:0] slot);
    logic [31:0] shifted;
    shifted = word >> (8 * (3 - int'(slot)));
    return shifted[ENT_W-1:0];
  endfunction

  function automatic logic [31:0] slot_put(input logic [31:0] word, input logic [1:0] slot,
                                           input logic [ENT_W-1:0] val);
    logic [31:0] mask;
    logic [31:0] ins;
    mask = 32'hFF00_0000 >> (8 * int'(slot));
    ins  = {val, 24'h0} >> (8 * int'(slot));
    return (word & ~mask) | ins;
  endfunction

  function automatic logic [CHAN_W-1:0] ent_chan(input logic [ENT_W-1:0] ent);
    return ent[7:4];
  endfunction

  function automatic logic [ATT_W-1:0] ent_att(input logic [ENT_W-1:0] ent);
    return ent[3:2];
  endfunction

  // Cycles between two timer fires.
  function automatic int unsigned trig_period(input int unsigned ivl);
    return 2 * ((ivl < IVL_FLOOR) ? IVL_FLOOR : ivl);
  endfunction

endpackage

// File: rtl/scan_seq_table.sv
module scan_seq_table
  import scan_seq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int PTR_W = $clog2(NUM_WORDS * SLOTS),
  localparam int WIDX_W = PTR_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_entry
);

  logic [31:0] words [NUM_WORDS];

  logic [WIDX_W-1:0] wr_word;
  logic [1:0]        wr_slot;
  logic [WIDX_W-1:0] rd_word;
  logic [1:0]        rd_slot;

  assign wr_word = wr_idx[PTR_W-1:2];
  assign wr_slot = wr_idx[1:0];
  assign rd_word = rd_idx[PTR_W-1:2];
  assign rd_slot = rd_idx[1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[w] <= '0;
      end else if (wr_en && (wr_word == WIDX_W'(w))) begin
        words[w] <= slot_put(words[w], wr_slot, wr_data);
      end
    end
  end

  assign rd_entry = slot_get(words[rd_word], rd_slot);

endmodule

// File: rtl/scan_seq_timer.sv
module scan_seq_timer
  import scan_seq_pkg::*;
#(
  parameter int IVL_W = 12,
  localparam int CNT_W = ((IVL_W + 1) > 7) ? (IVL_W + 1) : 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic             active;

  assign active = sel & en;
  assign period = CNT_W'(trig_period(32'(ivl)));
  assign fire   = active && (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || fire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ptr_clr,
  input  logic [PTR_W-1:0]  pat_len,
  input  logic              conv_done,
  input  logic [ENT_W-1:0]  entry,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [ATT_W-1:0]  conv_atten,
  output logic              busy,
  output logic              accept,
  output logic              overrun
);

  logic [PTR_W-1:0] ptr;
  logic             free;
  logic             launch;
  logic             drop;
  logic             unused_rsvd;

  assign unused_rsvd = ^entry[1:0];

  assign accept = busy & conv_done;
  assign free   = ~busy | accept;
  assign launch = fire & free;
  assign drop   = fire & ~free;
  assign rd_ptr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      conv_atten <= '0;
      ptr        <= '0;
      overrun    <= 1'b0;
    end else begin
      conv_start <= launch;
      if (launch) begin
        busy       <= 1'b1;
        conv_chan  <= ent_chan(entry);
        conv_atten <= ent_att(entry);
      end else if (accept) begin
        busy <= 1'b0;
      end
      if (ptr_clr) begin
        ptr <= '0;
      end else if (launch) begin
        ptr <= (ptr >= pat_len) ? '0 : ptr + PTR_W'(1);
      end
      if (drop) begin
        overrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_seq_out.sv
module scan_seq_out #(
  parameter int DATA_W = 12,
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              inv_en,
  input  logic [FCNT_W-1:0] frame_len,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_eof
);

  logic [FCNT_W-1:0] fcnt;
  logic              last;

  // A frame length of zero closes every frame after one sample.
  assign last = ({1'b0, fcnt} + (FCNT_W + 1)'(1)) >= {1'b0, frame_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_eof   <= 1'b0;
      fcnt      <= '0;
    end else begin
      smp_valid <= accept;
      smp_eof   <= accept & last;
      if (accept) begin
        smp_data <= inv_en ? ~conv_data : conv_data;
        fcnt     <= last ? '0 : fcnt + FCNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int IVL_W = 12,
  parameter int FCNT_W = 8,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(NUM_WORDS * SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [PTR_W-1:0]  tbl_wr_idx,
  input  logic [ENT_W-1:0]  tbl_wr_data,
  input  logic              ptr_clr,
  input  logic              tmr_sel,
  input  logic              tmr_en,
  input  logic [IVL_W-1:0]  interval,
  input  logic [PTR_W-1:0]  pat_len,
  input  logic [FCNT_W-1:0] frame_len,
  input  logic              inv_en,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [ATT_W-1:0]  conv_atten,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_eof,
  output logic              overrun
);

  logic             tmr_fire;
  logic             busy;
  logic             accept;
  logic [PTR_W-1:0] rd_ptr;
  logic [ENT_W-1:0] cur_entry;

  scan_seq_table #(.NUM_WORDS(NUM_WORDS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_data  (tbl_wr_data),
    .rd_idx   (rd_ptr),
    .rd_entry (cur_entry)
  );

  scan_seq_timer #(.IVL_W(IVL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (tmr_sel),
    .en    (tmr_en),
    .ivl   (interval),
    .fire  (tmr_fire)
  );

  scan_seq_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (tmr_fire),
    .ptr_clr    (ptr_clr),
    .pat_len    (pat_len),
    .conv_done  (conv_done),
    .entry      (cur_entry),
    .rd_ptr     (rd_ptr),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_atten (conv_atten),
    .busy       (busy),
    .accept     (accept),
    .overrun    (overrun)
  );

  scan_seq_out #(.DATA_W(DATA_W), .FCNT_W(FCNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .conv_data (conv_data),
    .inv_en    (inv_en),
    .frame_len (frame_len),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_eof   (smp_eof)
  );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_sel,
  input logic       tmr_en,
  input logic       tmr_fire,
  input logic       busy,
  input logic       conv_start,
  input logic [3:0] conv_chan,
  input logic       conv_done,
  input logic       smp_valid,
  input logic       smp_eof,
  input logic       overrun
);

  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(tmr_sel && tmr_en));

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && $past(busy)) |-> $stable(conv_chan));

  p_valid_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(conv_done && busy));

  p_eof_with_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_eof |-> smp_valid);

  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_drop_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_fire && busy && !conv_done) |=> (overrun && !conv_start));

  p_stray_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy) |=> !smp_valid);

endmodule

bind scan_seq scan_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_sel    (tmr_sel),
  .tmr_en     (tmr_en),
  .tmr_fire   (tmr_fire),
  .busy       (busy),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .smp_valid  (smp_valid),
  .smp_eof    (smp_eof),
  .overrun    (overrun)
);

// File: tb/scan_seq_test.sv
module scan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en;
  logic [3:0]  tbl_wr_idx;
  logic [7:0]  tbl_wr_data;
  logic        ptr_clr;
  logic        tmr_sel;
  logic        tmr_en;
  logic [11:0] interval;
  logic [3:0]  pat_len;
  logic [7:0]  frame_len;
  logic        inv_en;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [1:0]  conv_atten;
  logic        conv_done;
  logic [11:0] conv_data;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic        smp_eof;
  logic        overrun;

  logic        mdl_done;
  logic [11:0] mdl_data;
  logic        stray_done;
  logic [11:0] stray_data;

  assign conv_done = mdl_done | stray_done;
  assign conv_data = stray_done ? stray_data : mdl_data;

  always #2 clk = ~clk;

  scan_seq uut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_data(tbl_wr_data), .ptr_clr(ptr_clr), .tmr_sel(tmr_sel), .tmr_en(tmr_en),
    .interval(interval), .pat_len(pat_len), .frame_len(frame_len), .inv_en(inv_en),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_atten(conv_atten),
    .conv_done(conv_done), .conv_data(conv_data), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_eof(smp_eof), .overrun(overrun)
  );

  typedef struct {
    logic [11:0] data;
    logic        eof;
    string       tag;
  } item_t;

  item_t      sbq[$];
  logic [7:0] exp_tbl[16];
  int         cyc = 0;
  int         n_tests = 0;
  int         n_fail = 0;
  int         exp_ptr = 0;
  int         bench_len = 5;
  int         lat = 5;
  int         cm_cnt = 0;
  int         n_starts = 0;
  int         n_valid = 0;
  int         seq = 0;
  int         fcnt_b = 0;
  int         last_start = -1;
  int         exp_period = 80;
  string      per_tag = "R4";
  string      scan_tag = "R7";
  bit         after_clr = 1'b0;
  logic [3:0] cur_chan;
  logic [1:0] cur_att;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Converter model and driver side of the scoreboard.
  initial begin
    mdl_done = 1'b0;
    mdl_data = '0;
    forever begin
      @(negedge clk);
      mdl_done = 1'b0;
      if (cm_cnt > 0) begin
        cm_cnt--;
        if (cm_cnt == 0) begin
          item_t it;
          mdl_data = {cur_chan, cur_att, 6'(seq)};
          seq++;
          mdl_done = 1'b1;
          fcnt_b++;
          it.eof = (fcnt_b >= int'(frame_len));
          if (it.eof) fcnt_b = 0;
          it.data = inv_en ? ~mdl_data : mdl_data;
          it.tag  = inv_en ? "R10" : "R9";
          sbq.push_back(it);
        end
      end
      if (rst_n && conv_start) begin
        logic [7:0] e;
        string tg;
        check(cm_cnt == 0, "R12", "start while busy", cm_cnt, 0);
        if (last_start >= 0)
          check(cyc - last_start == exp_period, per_tag, "start spacing",
                cyc - last_start, exp_period);
        last_start = cyc;
        e  = exp_tbl[exp_ptr];
        tg = after_clr ? "R8" : scan_tag;
        after_clr = 1'b0;
        check(conv_chan == e[7:4], tg, "channel", conv_chan, e[7:4]);
        check(conv_atten == e[3:2], "R3", "attenuation", conv_atten, e[3:2]);
        exp_ptr  = (exp_ptr >= bench_len) ? 0 : exp_ptr + 1;
        cur_chan = conv_chan;
        cur_att  = conv_atten;
        cm_cnt   = lat;
        n_starts++;
      end
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && smp_valid) begin
        n_valid++;
        if (sbq.size() == 0) begin
          check(1'b0, "R13", "unexpected sample", smp_data, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(smp_data == it.data, it.tag, "sample data", smp_data, it.data);
          check(smp_eof == it.eof, "R11", "frame end", smp_eof, it.eof);
        end
      end
    end
  end

  initial begin
    wait (cyc >= 150000);
    check(1'b0, "watchdog", "timeout", cyc, 150000);
    finish_tb();
  end

  task automatic tbl_write(input int idx, input logic [7:0] b);
    tbl_wr_en   = 1'b1;
    tbl_wr_idx  = 4'(idx);
    tbl_wr_data = b;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wait_starts(input int k);
    int target;
    target = n_starts + k;
    while (n_starts < target) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s0;
    int v0;
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
    ptr_clr = 1'b0; tmr_sel = 1'b0; tmr_en = 1'b0; interval = 12'd40;
    pat_len = 4'd5; frame_len = 8'd5; inv_en = 1'b0;
    stray_done = 1'b0; stray_data = '0;
    for (int i = 0; i < 16; i++) exp_tbl[i] = {4'((i * 7 + 3) % 16), 2'(i % 4), 2'b11};

    idle(4);
    check(conv_start == 0 && smp_valid == 0, "R1", "outputs in reset", {conv_start, smp_valid}, 0);
    check(smp_eof == 0 && overrun == 0, "R1", "flags in reset", {smp_eof, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(conv_start == 0 && smp_valid == 0, "R1", "outputs after reset", {conv_start, smp_valid}, 0);
    check(overrun == 0, "R1", "overrun after reset", overrun, 0);

    for (int i = 0; i < 16; i++) tbl_write(i, exp_tbl[i]);

    // R4 / R7: plain scan over entries 0..5 with interval 40.
    scan_tag = "R7"; per_tag = "R4"; exp_period = 80; last_start = -1;
    tmr_sel = 1'b1; tmr_en = 1'b1;
    wait_starts(14);

    // R6: either control low stops triggers.
    tmr_en = 1'b0;
    idle(40);
    s0 = n_starts;
    idle(300);
    check(n_starts == s0, "R6", "starts with timer disabled", n_starts - s0, 0);
    tmr_en = 1'b1; tmr_sel = 1'b0;
    idle(300);
    check(n_starts == s0, "R6", "starts with timer deselected", n_starts - s0, 0);
    tmr_sel = 1'b0; tmr_en = 1'b0;

    // R13: stray done while idle.
    v0 = n_valid;
    stray_data = 12'h5A5; stray_done = 1'b1;
    @(negedge clk);
    stray_done = 1'b0;
    idle(5);
    check(n_valid == v0, "R13", "samples after stray done", n_valid - v0, 0);

    // R8, R2, R10, R5: clear pointer, rewrite one byte, invert, short interval.
    ptr_clr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0;
    exp_ptr = 0; after_clr = 1'b1;
    tbl_write(6, 8'hA6);
    exp_tbl[6] = 8'hA6;
    pat_len = 4'd7; bench_len = 7; scan_tag = "R2";
    inv_en = 1'b1;
    interval = 12'd10; per_tag = "R5"; exp_period = 80; last_start = -1;
    tmr_sel = 1'b1; tmr_en = 1'b1;
    wait_starts(9);

    // R4: longer interval.
    tmr_en = 1'b0;
    idle(40);
    interval = 12'd50; per_tag = "R4"; exp_period = 100; last_start = -1; scan_tag = "R7";
    tmr_en = 1'b1;
    wait_starts(5);

    // R12: done lands in the same cycle as the next trigger.
    tmr_en = 1'b0;
    idle(40);
    inv_en = 1'b0; interval = 12'd40; lat = 79;
    per_tag = "R12"; exp_period = 80; last_start = -1;
    tmr_en = 1'b1;
    wait_starts(5);
    check(overrun == 0, "R12", "overrun after coinciding done", overrun, 0);
    tmr_en = 1'b0;
    idle(120);

    // R12: slow converter, triggers dropped.
    lat = 200; exp_period = 240; last_start = -1;
    tmr_en = 1'b1;
    wait_starts(3);
    tmr_en = 1'b0;
    idle(300);
    check(overrun == 1, "R12", "overrun after dropped trigger", overrun, 1);
    check(sbq.size() == 0, "R9", "samples outstanding", sbq.size(), 0);
    check(n_valid == seq, "R9", "sample count", n_valid, seq);

    finish_tb();
  end

endmodule